// File: doc/BRIEF.md
# Multicast Message Broadcast Receiver

This block sits on a shared backplane as a write-only slave and takes in one-byte broadcast messages. A sender writes the byte to a fixed address window. The address carries a channel number and a 21-bit board-select mask. One write can reach any subset of boards, and every selected board keeps its own copy of the same byte. Each board compares its slot number against the mask. When its bit is set, the byte goes into one of two independent eight-entry queues.

A queue that holds data raises an interrupt to the local processor at a level that software programs for that channel. The processor acknowledges at that level and is told which channel it is serving. It then drains the queue through a read port. Once the queue is empty, service of that channel ends and the channel may interrupt again.

Top module: `mcast_msg_rx`

## Requirements
- R1: A bus write is considered only when address bits [31:24] equal 8'hA5. Any other value leaves all queues unchanged.
- R2: Board slot s (0 to 20) is selected when address bit 2+s is set. A single write may select any subset of slots. A slot_id of 21 or more is never selected.
- R3: Address bit 23 picks the channel: 0 for channel 0, 1 for channel 1. Each channel has its own queue, level, overflow flag and service state.
- R4: Each queue holds up to 8 bytes and returns them in arrival order. fifo_cnt[3:0] and fifo_cnt[7:4] give the fill of channels 0 and 1.
- R5: A selected write to a full queue, with no read of that queue in the same cycle, is dropped. It sets that channel's sticky overflow bit (chan_ovf[c]). The bit clears only on a config write to that channel with cfg_clr_ovf high.
- R6: Each channel has a 3-bit level that reset sets to 0 and a config write sets. A channel requests an interrupt while its queue is non-empty, it is not in service and its level is non-zero. Level 0 masks the channel.
- R7: irq_level shows the highest level among requesting channels, or 0 when no channel is requesting.
- R8: A cycle with iack_en high and level L puts into service the requesting channel whose level is L, with channel 0 winning a tie. The next cycle shows iack_done=1 and iack_chan. If no channel matches, iack_done stays 0.
- R9: A read (rd_en, rd_chan) is honoured only when that channel is in service and non-empty. It pops the head byte, and the next cycle shows that byte on rd_data with rd_valid=1. Any other read gives rd_valid=0 and changes no queue.
- R10: A channel leaves service at the first clock edge at which its queue is empty.
- R11: After reset all queues are empty, the overflow bits are clear, irq_level is 0 and rd_valid and iack_done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_id | input | 5 | This board's slot number |
| bus_we | input | 1 | Bus write strobe, one cycle per write |
| bus_addr | input | 32 | Bus write address (tag, channel, mask) |
| bus_wdata | input | 8 | Message byte |
| cfg_we | input | 1 | Local config write |
| cfg_chan | input | 1 | Channel addressed by the config write |
| cfg_level | input | 3 | Interrupt level to store |
| cfg_clr_ovf | input | 1 | Clear the channel's overflow bit with this config write |
| iack_en | input | 1 | Interrupt acknowledge strobe |
| iack_level | input | 3 | Level being acknowledged |
| rd_en | input | 1 | Message read strobe |
| rd_chan | input | 1 | Channel to read |
| rd_data | output | 8 | Byte returned by the last honoured read |
| rd_valid | output | 1 | rd_data holds a byte read in the previous cycle |
| irq_level | output | 3 | Highest requesting level, 0 if none |
| iack_done | output | 1 | Previous acknowledge matched a channel |
| iack_chan | output | 1 | Channel granted by that acknowledge |
| chan_ovf | output | 2 | Sticky overflow bit per channel |
| fifo_cnt | output | 8 | Fill counts, 4 bits per channel |

## Verification
The assertions assume that bus_we, iack_en, rd_en and cfg_we are single-cycle strobes sampled at the rising edge. They also assume that slot_id is held steady between bus writes, because the mask is decoded against it in the same cycle. The stimulus changes inputs only at falling edges. It changes slot_id only while no write strobe is high, and it reads only after an acknowledge has granted the channel. The one exception is a deliberate early read used to show that the read is refused. Overflow is reached by writing past the queue depth with no read pending, so the drop rule is tested without a same-cycle pop.

// File: rtl/mcast_pkg.sv
package mcast_pkg;
  localparam int unsigned ADDR_W    = 32;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned NUM_CH    = 2;
  localparam int unsigned NUM_SLOTS = 21;
  localparam int unsigned SLOT_W    = 5;
  localparam int unsigned DEPTH     = 8;
  localparam int unsigned LVL_W     = 3;
  localparam int unsigned TAG_W     = 8;
  localparam logic [7:0]  WIN_TAG   = 8'hA5;
  localparam int unsigned MASK_LSB  = 2;
  localparam int unsigned CHAN_LSB  = 23;
endpackage

// File: rtl/mcast_addr_dec.sv
module mcast_addr_dec #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned NUM_CH    = 2,
  parameter int unsigned NUM_SLOTS = 21,
  parameter int unsigned SLOT_W    = 5,
  parameter int unsigned TAG_W     = 8,
  parameter logic [TAG_W-1:0] TAG  = 8'hA5,
  parameter int unsigned MASK_LSB  = 2,
  parameter int unsigned CHAN_LSB  = 23
) (
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [SLOT_W-1:0] slot_id,
  output logic [NUM_CH-1:0] push
);
  localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic                 tag_hit;
  logic [NUM_SLOTS-1:0] mask_bits;
  logic                 slot_sel;
  logic [CH_W-1:0]      ch_sel;

  assign tag_hit   = bus_addr[ADDR_W-1 -: TAG_W] == TAG;
  assign mask_bits = bus_addr[MASK_LSB +: NUM_SLOTS];
  assign ch_sel    = bus_addr[CHAN_LSB +: CH_W];

  // slots outside the mask range never match
  always_comb begin
    slot_sel = 1'b0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (slot_id == SLOT_W'(i)) slot_sel = mask_bits[i];
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_push
    assign push[c] = bus_we && tag_hit && slot_sel && (ch_sel == CH_W'(c));
  end
endmodule

// File: rtl/mcast_fifo.sv
module mcast_fifo #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop,
  input  logic              clr_ovf,
  output logic [DATA_W-1:0] head,
  output logic [CNT_W-1:0]  cnt,
  output logic              ovf
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              ovf_q, ovf_d;
  logic              full, do_pop, do_push;

  assign full    = cnt_q == CNT_W'(DEPTH);
  assign do_pop  = pop && (cnt_q != '0);
  assign do_push = push && (!full || do_pop);

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    ovf_d  = ovf_q;
    if (do_push) wptr_d = (wptr_q == PTR_W'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
    if (do_pop)  rptr_d = (rptr_q == PTR_W'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
    if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
    if (clr_ovf) ovf_d = 1'b0;
    if (push && !do_push) ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
      ovf_q  <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wptr_q] <= wdata;
  end

  assign head = mem_q[rptr_q];
  assign cnt  = cnt_q;
  assign ovf  = ovf_q;

  // R4
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  // R5
  drop_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && full) |=> (cnt_q == CNT_W'(DEPTH)) && ovf_q);
  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !clr_ovf) |=> ovf_q);
endmodule

// File: rtl/mcast_irq.sv
module mcast_irq #(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned LVL_W  = 3,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CH_W-1:0]   cfg_chan,
  input  logic [LVL_W-1:0]  cfg_level,
  input  logic [NUM_CH-1:0] nonempty,
  input  logic              iack_en,
  input  logic [LVL_W-1:0]  iack_level,
  output logic [NUM_CH-1:0] in_svc,
  output logic [LVL_W-1:0]  irq_level,
  output logic              iack_done,
  output logic [CH_W-1:0]   iack_chan
);
  logic [LVL_W-1:0]  lvl_q [NUM_CH];
  logic [LVL_W-1:0]  lvl_d [NUM_CH];
  logic [NUM_CH-1:0] svc_q, svc_d, req, grant;
  logic              done_q, done_d;
  logic [CH_W-1:0]   gch_q, gch_d;
  logic [LVL_W-1:0]  top_lvl;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_req
    assign req[c] = nonempty[c] && !svc_q[c] && (lvl_q[c] != '0);
  end

  always_comb begin
    top_lvl = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (req[c] && lvl_q[c] > top_lvl) top_lvl = lvl_q[c];
    end
  end

  // lowest-numbered matching channel wins the acknowledge
  always_comb begin
    grant = '0;
    gch_d = gch_q;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (iack_en && req[c] && lvl_q[c] == iack_level) begin
        grant = '0;
        grant[c] = 1'b1;
        gch_d = CH_W'(c);
      end
    end
    done_d = |grant;
    svc_d  = (svc_q & nonempty) | grant;
    for (int c = 0; c < NUM_CH; c++) begin
      lvl_d[c] = (cfg_we && cfg_chan == CH_W'(c)) ? cfg_level : lvl_q[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      svc_q  <= '0;
      done_q <= 1'b0;
      gch_q  <= '0;
      for (int c = 0; c < NUM_CH; c++) lvl_q[c] <= '0;
    end else begin
      svc_q  <= svc_d;
      done_q <= done_d;
      gch_q  <= gch_d;
      for (int c = 0; c < NUM_CH; c++) lvl_q[c] <= lvl_d[c];
    end
  end

  assign in_svc    = svc_q;
  assign irq_level = top_lvl;
  assign iack_done = done_q;
  assign iack_chan = gch_q;

  // R8
  iack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iack_done |-> $past(iack_en));
  // R7
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level != '0) |-> (nonempty != '0));
  // R10
  svc_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nonempty == '0) |=> (svc_q == '0) || $past(iack_en));
endmodule

// File: rtl/mcast_msg_rx.sv
module mcast_msg_rx
  import mcast_pkg::*;
#(
  parameter int unsigned P_ADDR_W    = ADDR_W,
  parameter int unsigned P_DATA_W    = DATA_W,
  parameter int unsigned P_NUM_CH    = NUM_CH,
  parameter int unsigned P_NUM_SLOTS = NUM_SLOTS,
  parameter int unsigned P_SLOT_W    = SLOT_W,
  parameter int unsigned P_DEPTH     = DEPTH,
  parameter int unsigned P_LVL_W     = LVL_W,
  localparam int unsigned CH_W  = (P_NUM_CH > 1) ? $clog2(P_NUM_CH) : 1,
  localparam int unsigned CNT_W = $clog2(P_DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [P_SLOT_W-1:0]       slot_id,
  input  logic                      bus_we,
  input  logic [P_ADDR_W-1:0]       bus_addr,
  input  logic [P_DATA_W-1:0]       bus_wdata,
  input  logic                      cfg_we,
  input  logic [CH_W-1:0]           cfg_chan,
  input  logic [P_LVL_W-1:0]        cfg_level,
  input  logic                      cfg_clr_ovf,
  input  logic                      iack_en,
  input  logic [P_LVL_W-1:0]        iack_level,
  input  logic                      rd_en,
  input  logic [CH_W-1:0]           rd_chan,
  output logic [P_DATA_W-1:0]       rd_data,
  output logic                      rd_valid,
  output logic [P_LVL_W-1:0]        irq_level,
  output logic                      iack_done,
  output logic [CH_W-1:0]           iack_chan,
  output logic [P_NUM_CH-1:0]       chan_ovf,
  output logic [P_NUM_CH*CNT_W-1:0] fifo_cnt
);
  logic [P_NUM_CH-1:0] push, pop, nonempty, in_svc, clr;
  logic [P_DATA_W-1:0] head [P_NUM_CH];
  logic [CNT_W-1:0]    cnt  [P_NUM_CH];
  logic                rd_ok;
  logic [P_DATA_W-1:0] rdat_q, rdat_d;
  logic                rval_q;

  mcast_addr_dec #(
    .ADDR_W(P_ADDR_W), .NUM_CH(P_NUM_CH), .NUM_SLOTS(P_NUM_SLOTS),
    .SLOT_W(P_SLOT_W), .TAG_W(TAG_W), .TAG(WIN_TAG),
    .MASK_LSB(MASK_LSB), .CHAN_LSB(CHAN_LSB)
  ) dec_i (
    .bus_we(bus_we), .bus_addr(bus_addr), .slot_id(slot_id), .push(push)
  );

  for (genvar c = 0; c < P_NUM_CH; c++) begin : g_ch
    assign clr[c]      = cfg_we && cfg_clr_ovf && (cfg_chan == CH_W'(c));
    assign pop[c]      = rd_ok && (rd_chan == CH_W'(c));
    assign nonempty[c] = cnt[c] != '0;
    assign fifo_cnt[c*CNT_W +: CNT_W] = cnt[c];

    mcast_fifo #(.DEPTH(P_DEPTH), .DATA_W(P_DATA_W)) fifo_i (
      .clk(clk), .rst_n(rst_n), .push(push[c]), .wdata(bus_wdata),
      .pop(pop[c]), .clr_ovf(clr[c]), .head(head[c]), .cnt(cnt[c]),
      .ovf(chan_ovf[c])
    );
  end

  mcast_irq #(.NUM_CH(P_NUM_CH), .LVL_W(P_LVL_W)) irq_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_chan(cfg_chan),
    .cfg_level(cfg_level), .nonempty(nonempty), .iack_en(iack_en),
    .iack_level(iack_level), .in_svc(in_svc), .irq_level(irq_level),
    .iack_done(iack_done), .iack_chan(iack_chan)
  );

  // a read needs a granted, non-empty channel
  assign rd_ok  = rd_en && in_svc[rd_chan] && nonempty[rd_chan];
  assign rdat_d = rd_ok ? head[rd_chan] : rdat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdat_q <= '0;
      rval_q <= 1'b0;
    end else begin
      rdat_q <= rdat_d;
      rval_q <= rd_ok;
    end
  end

  assign rd_data  = rdat_q;
  assign rd_valid = rval_q;

  // R1
  window_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push != '0) |-> (bus_addr[P_ADDR_W-1 -: TAG_W] == WIN_TAG));
  // R3
  one_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(push));
  // R9
  read_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_en));
endmodule

// File: tb/mcast_msg_rx_tb_top.sv
module mcast_msg_rx_tb_top;
  logic        clk, rst_n;
  logic [4:0]  slot_id;
  logic        bus_we, cfg_we, cfg_chan, cfg_clr_ovf, iack_en, rd_en, rd_chan;
  logic [31:0] bus_addr;
  logic [7:0]  bus_wdata, rd_data;
  logic [2:0]  cfg_level, iack_level, irq_level;
  logic        rd_valid, iack_done, iack_chan;
  logic [1:0]  chan_ovf;
  logic [7:0]  fifo_cnt;
  int          n_chk, n_fail;
  bit          finished;

  mcast_msg_rx dut_i (
    .clk(clk), .rst_n(rst_n), .slot_id(slot_id), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cfg_we(cfg_we),
    .cfg_chan(cfg_chan), .cfg_level(cfg_level), .cfg_clr_ovf(cfg_clr_ovf),
    .iack_en(iack_en), .iack_level(iack_level), .rd_en(rd_en),
    .rd_chan(rd_chan), .rd_data(rd_data), .rd_valid(rd_valid),
    .irq_level(irq_level), .iack_done(iack_done), .iack_chan(iack_chan),
    .chan_ovf(chan_ovf), .fifo_cnt(fifo_cnt)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {addr, data, expected count ch0, expected count ch1}, slot 5
  localparam logic [47:0] VEC [8] = '{
    {32'hA500_0080, 8'h11, 4'd1, 4'd1 - 4'd1},
    {32'hA580_0080, 8'h22, 4'd1, 4'd1},
    {32'hA500_0040, 8'h33, 4'd1, 4'd1},
    {32'hA400_0080, 8'h44, 4'd1, 4'd1},
    {32'hA57F_FFFC, 8'h55, 4'd2, 4'd1},
    {32'hA5FF_FFFC, 8'h66, 4'd2, 4'd2},
    {32'hA500_00C0, 8'h77, 4'd3, 4'd2},
    {32'hA580_0000, 8'h88, 4'd3, 4'd2}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [31:0] a, logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic cfg(logic ch, logic [2:0] lv, logic clr);
    cfg_we = 1'b1; cfg_chan = ch; cfg_level = lv; cfg_clr_ovf = clr;
    @(negedge clk);
    cfg_we = 1'b0; cfg_clr_ovf = 1'b0;
  endtask

  task automatic ack(logic [2:0] lv);
    iack_en = 1'b1; iack_level = lv;
    @(negedge clk);
    iack_en = 1'b0;
  endtask

  task automatic rd(logic ch);
    rd_en = 1'b1; rd_chan = ch;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; finished = 1'b0;
    rst_n = 1'b0; slot_id = 5'd5; bus_we = 0; bus_addr = '0; bus_wdata = '0;
    cfg_we = 0; cfg_chan = 0; cfg_level = 0; cfg_clr_ovf = 0;
    iack_en = 0; iack_level = 0; rd_en = 0; rd_chan = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 cnt", fifo_cnt, 8'h00);
    chk("R11 ovf", chan_ovf, 2'b00);
    chk("R11 irq", irq_level, 3'd0);
    chk("R11 rval", rd_valid, 1'b0);
    chk("R11 iack", iack_done, 1'b0);

    // R1 R2 R3 vector walk
    for (int i = 0; i < 8; i++) begin
      bus_wr(VEC[i][47:16], VEC[i][15:8]);
      chk("R1/R2/R3 cnt0", fifo_cnt[3:0], VEC[i][7:4]);
      chk("R1/R2/R3 cnt1", fifo_cnt[7:4], VEC[i][3:0]);
    end
    // R6 level 0 masks request
    chk("R6 masked", irq_level, 3'd0);
    cfg(1'b0, 3'd3, 1'b0);
    cfg(1'b1, 3'd5, 1'b0);
    // R7 highest level
    chk("R7 top", irq_level, 3'd5);
    // R9 read before acknowledge is refused
    rd(1'b0);
    chk("R9 early rval", rd_valid, 1'b0);
    chk("R9 early cnt", fifo_cnt[3:0], 4'd3);
    // R8 acknowledge
    ack(3'd5);
    chk("R8 done", iack_done, 1'b1);
    chk("R8 chan", iack_chan, 1'b1);
    chk("R7 after ack", irq_level, 3'd3);
    ack(3'd3);
    chk("R8 done0", iack_done, 1'b1);
    chk("R8 chan0", iack_chan, 1'b0);
    chk("R7 none", irq_level, 3'd0);
    // R4 order, R9 data
    rd(1'b0); chk("R9 v", rd_valid, 1'b1); chk("R4 d0", rd_data, 8'h11);
    rd(1'b0); chk("R4 d1", rd_data, 8'h55);
    rd(1'b0); chk("R4 d2", rd_data, 8'h77);
    chk("R4 empty", fifo_cnt[3:0], 4'd0);
    rd(1'b0); chk("R9 empty read", rd_valid, 1'b0);
    rd(1'b1); chk("R4 c1d0", rd_data, 8'h22);
    rd(1'b1); chk("R4 c1d1", rd_data, 8'h66);
    @(negedge clk);
    // R5 overflow on ch0
    for (int i = 0; i < 9; i++) bus_wr(32'hA500_0080, 8'(i));
    chk("R5 full", fifo_cnt[3:0], 4'd8);
    chk("R5 ovf", chan_ovf, 2'b01);
    // R10 service ended, so ch0 requests again
    chk("R10 rerequest", irq_level, 3'd3);
    cfg(1'b0, 3'd0, 1'b0);
    chk("R6 level0", irq_level, 3'd0);
    chk("R5 sticky", chan_ovf, 2'b01);
    cfg(1'b0, 3'd3, 1'b1);
    chk("R5 clear", chan_ovf, 2'b00);
    ack(3'd6);
    chk("R8 nomatch", iack_done, 1'b0);
    ack(3'd3);
    rd(1'b0); chk("R5 kept first", rd_data, 8'h00);
    // R2 slot boundaries on ch1
    slot_id = 5'd20;
    bus_wr(32'hA5C0_0000, 8'hAB);
    chk("R2 slot20", fifo_cnt[7:4], 4'd1);
    slot_id = 5'd21;
    bus_wr(32'hA5FF_FFFF, 8'hCD);
    chk("R2 slot21", fifo_cnt[7:4], 4'd1);
    finish_run();
  end
endmodule